// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block keeps the sharer record for one memory block in a directory-based coherence controller. Instead of one presence bit per processor, it stores a small number of processor-ID pointers, each `log2(NPROC)` bits wide, with a valid bit per pointer. Requests arrive one at a time: record a sharer, drop a sharer, a write by some processor that must invalidate every other copy, or a full clear. The invalidation targets come out serially, one processor ID per cycle, with a valid and a last flag. While such a list is being emitted, the entry is busy and ignores new requests.

When a new sharer arrives and every pointer is in use, the `mode` input picks what happens. In broadcast mode, a flag is raised and the next write invalidates every processor. In evict mode, the sharer held by a round-robin slot is invalidated at once and its slot takes the newcomer. In coarse mode, the pointer storage is reused as a group vector: each bit stands for a fixed power-of-two group of processors. A write then invalidates whole groups. The `mode` input is meant to change only between a clear or write and the next overflow.

Top module: `dir_lptr_entry`

## Requirements
- R1: After reset the entry holds no sharers: `busy`, `inv_valid` and `ovf` are low, and a write request (op code 2) emits no target.
- R2: An add request (op code 0) records a new ID in the lowest free pointer slot. Adding an ID that is already recorded changes nothing, so the ID is emitted at most once by a later write.
- R3: A remove request (op code 1) frees the slot holding the given ID. Removing an unknown ID, or removing any ID while `ovf` is high, has no effect.
- R4: A write request (op code 2) from processor W emits every recorded sharer except W. Targets come out one per cycle in ascending ID order, starting the cycle after acceptance. `inv_last` is set on the final target only, and nothing is emitted when there are no targets.
- R5: When a write request completes, the entry holds W as its only sharer and `ovf` is low. A following write from another processor emits exactly W.
- R6: In broadcast mode (`mode` 0 or 3), adding a new ID to a full entry raises `ovf`. The next write then targets all processors except the writer.
- R7: In evict mode (`mode` 1), adding a new ID to a full entry emits one invalidation of the ID held in the victim slot, flagged last, on the next cycle. The new ID takes that slot. Victim slots rotate 0, 1, ..., NPTR-1 starting from slot 0 after a clear or write, and `ovf` stays low.
- R8: In coarse mode (`mode` 2), adding a new ID to a full entry raises `ovf`. Each group bit then covers IDs g*G to g*G+G-1, where G is the smallest power of two with G*NPTR*log2(NPROC) >= NPROC. Group bits are set for all old sharers and the new one, later adds set their group's bit, and a write targets every ID of every set group except the writer.
- R9: While `busy` is high, every request is ignored.
- R10: A clear request (op code 3) empties the entry and lowers `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Overflow policy: 0/3 broadcast, 1 evict, 2 coarse |
| op_valid | input | 1 | Request strobe, taken when `busy` is low |
| op_code | input | 2 | 0 add, 1 remove, 2 write-invalidate, 3 clear |
| op_id | input | log2(NPROC) | Processor ID of the request |
| busy | output | 1 | Target list pending; requests ignored |
| inv_valid | output | 1 | `inv_id` is an invalidation target this cycle |
| inv_id | output | log2(NPROC) | Processor to invalidate |
| inv_last | output | 1 | Final target of the current list |
| ovf | output | 1 | Entry is in broadcast or coarse overflow |

## Verification
For every policy and every writer ID, the bench adds zero to five sharers whose IDs are derived arithmetically from the writer. Some runs also include a removal and a repeated add. Zero to three adds exercise plain pointer tracking and duplicate suppression. Four or five adds separate the three overflow behaviours: all-but-writer for broadcast, a single rotating victim for evict, and group-granular targets for coarse. A second write checks that the writer alone remains. A directed run sends requests during a long broadcast list to show they are dropped.

// File: rtl/dir_lptr_pkg.sv
package dir_lptr_pkg;

    typedef enum logic [1:0] {
        OP_ADD    = 2'd0,
        OP_REMOVE = 2'd1,
        OP_WRINV  = 2'd2,
        OP_CLEAR  = 2'd3
    } dir_op_e;

    typedef enum logic [1:0] {
        OVF_BCAST  = 2'd0,
        OVF_EVICT  = 2'd1,
        OVF_COARSE = 2'd2,
        OVF_BCAST2 = 2'd3
    } ovf_mode_e;

    // Smallest power of two g with g * vec_bits >= nproc.
    function automatic int unsigned coarse_grp(input int unsigned nproc,
                                               input int unsigned vec_bits);
        int unsigned g;
        g = 1;
        for (int k = 0; k < 32; k++) begin
            if (g * vec_bits < nproc) g = g * 2;
        end
        return g;
    endfunction

endpackage

// File: rtl/dir_tgt_scan.sv
module dir_tgt_scan #(
    parameter int NPROC = 16,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NPROC-1:0] load_mask,
    output logic             busy,
    output logic             inv_valid,
    output logic [ID_W-1:0]  inv_id,
    output logic             inv_last
);
    logic [NPROC-1:0] mask_q;
    logic [NPROC-1:0] rest;

    assign busy      = |mask_q;
    assign inv_valid = busy;
    assign rest      = mask_q & (mask_q - NPROC'(1));
    assign inv_last  = busy && (rest == '0);

    always_comb begin
        inv_id = '0;
        for (int k = NPROC - 1; k >= 0; k--) begin
            if (mask_q[k]) inv_id = ID_W'(k);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       mask_q <= '0;
        else if (load) mask_q <= load_mask;
        else if (busy) mask_q <= rest;
    end

    AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        inv_valid && !inv_last |=> inv_valid && (inv_id > $past(inv_id))); // R4
    AST_LAST_DRAINS: assert property (@(posedge clk) disable iff (rst)
        inv_valid && inv_last |=> !inv_valid); // R4

endmodule

// File: rtl/dir_ptr_store.sv
module dir_ptr_store
    import dir_lptr_pkg::*;
#(
    parameter int NPROC  = 16,
    parameter int NPTR   = 3,
    parameter int ID_W   = 4,
    parameter int PBITS  = 12,
    parameter int GRP    = 2,
    parameter int GRP_SH = 1,
    parameter int NGRP   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  dir_op_e          op,
    input  logic [ID_W-1:0]  id,
    input  ovf_mode_e        mode,
    output logic             ovf,
    output logic             tgt_load,
    output logic [NPROC-1:0] tgt_mask
);
    localparam int RR_W = (NPTR > 1) ? $clog2(NPTR) : 1;

    logic [NPTR-1:0]  vld_q, vld_n;
    logic [PBITS-1:0] bits_q, bits_n;
    logic             bc_q, bc_n, cv_q, cv_n;
    logic [RR_W-1:0]  rr_q, rr_n;

    logic [NPTR-1:0]  hit;
    logic             has_free;
    logic [RR_W-1:0]  free_idx;
    logic [NPROC-1:0] share_mask, self_bit, victim_bit;
    logic [NGRP-1:0]  grp_vec;
    logic [ID_W-1:0]  victim_id;

    assign ovf = bc_q | cv_q;

    always_comb begin
        hit      = '0;
        has_free = 1'b0;
        free_idx = '0;
        for (int j = NPTR - 1; j >= 0; j--) begin
            hit[j] = vld_q[j] && (bits_q[j*ID_W +: ID_W] == id);
            if (!vld_q[j]) begin
                has_free = 1'b1;
                free_idx = RR_W'(j);
            end
        end
    end

    always_comb begin
        share_mask = '0;
        if (cv_q) begin
            for (int p = 0; p < NPROC; p++) share_mask[p] = bits_q[p / GRP];
        end else if (bc_q) begin
            share_mask = '1;
        end else begin
            for (int j = 0; j < NPTR; j++) begin
                if (vld_q[j]) share_mask[bits_q[j*ID_W +: ID_W]] = 1'b1;
            end
        end
        self_bit       = '0;
        self_bit[id]   = 1'b1;
        victim_id      = bits_q[int'(rr_q)*ID_W +: ID_W];
        victim_bit     = '0;
        victim_bit[victim_id] = 1'b1;
        grp_vec        = '0;
        for (int j = 0; j < NPTR; j++) begin
            grp_vec[bits_q[j*ID_W +: ID_W] >> GRP_SH] = 1'b1;
        end
        grp_vec[id >> GRP_SH] = 1'b1;
    end

    always_comb begin
        vld_n    = vld_q;
        bits_n   = bits_q;
        bc_n     = bc_q;
        cv_n     = cv_q;
        rr_n     = rr_q;
        tgt_load = 1'b0;
        tgt_mask = '0;
        if (acc) begin
            unique case (op)
                OP_ADD: begin
                    if (cv_q) begin
                        bits_n[id >> GRP_SH] = 1'b1;
                    end else if (!bc_q && (hit == '0)) begin
                        if (has_free) begin
                            vld_n[free_idx]                       = 1'b1;
                            bits_n[int'(free_idx)*ID_W +: ID_W]   = id;
                        end else begin
                            unique case (mode)
                                OVF_EVICT: begin
                                    tgt_load = 1'b1;
                                    tgt_mask = victim_bit;
                                    bits_n[int'(rr_q)*ID_W +: ID_W] = id;
                                    rr_n = (rr_q == RR_W'(NPTR - 1)) ? '0 : rr_q + RR_W'(1);
                                end
                                OVF_COARSE: begin
                                    bits_n             = '0;
                                    bits_n[NGRP-1:0]   = grp_vec;
                                    vld_n              = '0;
                                    cv_n               = 1'b1;
                                end
                                default: bc_n = 1'b1;
                            endcase
                        end
                    end
                end
                OP_REMOVE: begin
                    if (!bc_q && !cv_q) vld_n = vld_q & ~hit;
                end
                OP_WRINV: begin
                    tgt_load   = 1'b1;
                    tgt_mask   = share_mask & ~self_bit;
                    vld_n      = '0;
                    vld_n[0]   = 1'b1;
                    bits_n     = '0;
                    bits_n[ID_W-1:0] = id;
                    bc_n       = 1'b0;
                    cv_n       = 1'b0;
                    rr_n       = '0;
                end
                default: begin
                    vld_n  = '0;
                    bits_n = '0;
                    bc_n   = 1'b0;
                    cv_n   = 1'b0;
                    rr_n   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            bits_q <= '0;
            bc_q   <= 1'b0;
            cv_q   <= 1'b0;
            rr_q   <= '0;
        end else begin
            vld_q  <= vld_n;
            bits_q <= bits_n;
            bc_q   <= bc_n;
            cv_q   <= cv_n;
            rr_q   <= rr_n;
        end
    end

    logic dup_ptr;
    always_comb begin
        dup_ptr = 1'b0;
        for (int a = 0; a < NPTR; a++) begin
            for (int b = a + 1; b < NPTR; b++) begin
                if (vld_q[a] && vld_q[b] &&
                    bits_q[a*ID_W +: ID_W] == bits_q[b*ID_W +: ID_W]) dup_ptr = 1'b1;
            end
        end
    end

    AST_NO_DUP_PTR: assert property (@(posedge clk) disable iff (rst)
        !cv_q |-> !dup_ptr); // R2
    AST_OVF_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bc_q && cv_q)); // R8
    AST_COARSE_NO_PTR: assert property (@(posedge clk) disable iff (rst)
        cv_q |-> (vld_q == '0)); // R8

endmodule

// File: rtl/dir_lptr_entry.sv
module dir_lptr_entry
    import dir_lptr_pkg::*;
#(
    parameter int NPROC = 16,
    parameter int NPTR  = 3,
    localparam int ID_W = $clog2(NPROC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode,
    input  logic            op_valid,
    input  logic [1:0]      op_code,
    input  logic [ID_W-1:0] op_id,
    output logic            busy,
    output logic            inv_valid,
    output logic [ID_W-1:0] inv_id,
    output logic            inv_last,
    output logic            ovf
);
    localparam int PBITS  = NPTR * ID_W;
    localparam int GRP    = int'(coarse_grp(NPROC, PBITS));
    localparam int GRP_SH = (GRP > 1) ? $clog2(GRP) : 0;
    localparam int NGRP   = (NPROC + GRP - 1) / GRP;

    logic             acc;
    logic             st_load;
    logic [NPROC-1:0] st_mask;

    assign acc = op_valid && !busy;

    dir_ptr_store #(
        .NPROC(NPROC), .NPTR(NPTR), .ID_W(ID_W), .PBITS(PBITS),
        .GRP(GRP), .GRP_SH(GRP_SH), .NGRP(NGRP)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .op       (dir_op_e'(op_code)),
        .id       (op_id),
        .mode     (ovf_mode_e'(mode)),
        .ovf      (ovf),
        .tgt_load (st_load),
        .tgt_mask (st_mask)
    );

    dir_tgt_scan #(.NPROC(NPROC), .ID_W(ID_W)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .load      (st_load),
        .load_mask (st_mask),
        .busy      (busy),
        .inv_valid (inv_valid),
        .inv_id    (inv_id),
        .inv_last  (inv_last)
    );

    AST_IDLE_LOAD: assert property (@(posedge clk) disable iff (rst)
        busy |-> !st_load); // R9
    AST_WRINV_CLEARS_OVF: assert property (@(posedge clk) disable iff (rst)
        acc && op_code == 2'd2 |=> !ovf); // R5

endmodule

// File: tb/dir_lptr_entry_tb.sv
module dir_lptr_entry_tb;
    localparam int NPROC = 16;
    localparam int NPTR  = 3;
    localparam int GRP   = 2;   // 12 pointer bits cover 16 IDs in groups of 2

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic       op_valid = 1'b0;
    logic [1:0] op_code = 2'd0;
    logic [3:0] op_id = 4'd0;
    logic       busy, inv_valid, inv_last, ovf;
    logic [3:0] inv_id;

    always #2 clk = ~clk;

    dir_lptr_entry #(.NPROC(NPROC), .NPTR(NPTR)) u_dut (
        .clk(clk), .rst(rst), .mode(mode), .op_valid(op_valid),
        .op_code(op_code), .op_id(op_id), .busy(busy),
        .inv_valid(inv_valid), .inv_id(inv_id), .inv_last(inv_last), .ovf(ovf)
    );

    int checks = 0;
    int errors = 0;

    // emission collector
    logic [15:0] got;
    int got_cnt, last_cnt, last_at;
    bit order_bad;
    logic [3:0] prev_id;
    always @(negedge clk) begin
        if (!rst && inv_valid) begin
            if (got_cnt > 0 && inv_id <= prev_id) order_bad = 1'b1;
            got[inv_id] = 1'b1;
            got_cnt++;
            prev_id = inv_id;
            if (inv_last) begin
                last_cnt++;
                last_at = got_cnt;
            end
        end
    end

    // reference model
    logic       m_vld [NPTR];
    logic [3:0] m_id  [NPTR];
    int         m_rr;
    bit         m_bc, m_cv;
    logic [7:0] m_grp;

    task automatic m_clear();
        for (int j = 0; j < NPTR; j++) begin m_vld[j] = 1'b0; m_id[j] = 4'd0; end
        m_rr = 0; m_bc = 0; m_cv = 0; m_grp = '0;
    endtask

    task automatic m_add(input logic [3:0] id, input int md, output logic [15:0] ev);
        bit found;
        int free_slot;
        ev = '0; found = 0; free_slot = -1;
        if (m_cv) m_grp[id / GRP] = 1'b1;
        else if (!m_bc) begin
            for (int j = 0; j < NPTR; j++) if (m_vld[j] && m_id[j] == id) found = 1;
            for (int j = NPTR - 1; j >= 0; j--) if (!m_vld[j]) free_slot = j;
            if (!found) begin
                if (free_slot >= 0) begin
                    m_vld[free_slot] = 1'b1; m_id[free_slot] = id;
                end else if (md == 1) begin
                    ev[m_id[m_rr]] = 1'b1; m_id[m_rr] = id; m_rr = (m_rr + 1) % NPTR;
                end else if (md == 2) begin
                    m_grp = '0;
                    for (int j = 0; j < NPTR; j++) begin m_grp[m_id[j] / GRP] = 1'b1; m_vld[j] = 1'b0; end
                    m_grp[id / GRP] = 1'b1;
                    m_cv = 1;
                end else m_bc = 1;
            end
        end
    endtask

    task automatic m_remove(input logic [3:0] id);
        if (!m_bc && !m_cv)
            for (int j = 0; j < NPTR; j++) if (m_vld[j] && m_id[j] == id) m_vld[j] = 1'b0;
    endtask

    task automatic m_winv(input logic [3:0] w, output logic [15:0] exp);
        exp = '0;
        if (m_cv) begin
            for (int p = 0; p < NPROC; p++) if (m_grp[p / GRP]) exp[p] = 1'b1;
        end else if (m_bc) exp = '1;
        else for (int j = 0; j < NPTR; j++) if (m_vld[j]) exp[m_id[j]] = 1'b1;
        exp[w] = 1'b0;
        m_clear();
        m_vld[0] = 1'b1; m_id[0] = w;
    endtask

    task automatic issue(input logic [1:0] code, input logic [3:0] id);
        @(negedge clk);
        while (busy) @(negedge clk);
        got = '0; got_cnt = 0; last_cnt = 0; last_at = 0; order_bad = 0;
        op_valid = 1'b1; op_code = code; op_id = id;
        @(negedge clk);
        op_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic chk_emit(input string req, input logic [15:0] exp);
        checks++;
        if (got !== exp || got_cnt != $countones(exp) || order_bad ||
            (got_cnt > 0 && (last_cnt != 1 || last_at != got_cnt))) begin
            errors++;
            $display("FAIL %s: targets %h (n=%0d last=%0d@%0d order_bad=%0d) expected %h",
                     req, got, got_cnt, last_cnt, last_at, order_bad, exp);
        end
    endtask

    task automatic chk_ovf(input string req, input bit exp);
        checks++;
        if (ovf !== exp) begin
            errors++;
            $display("FAIL %s: ovf %b expected %b", req, ovf, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run not finished, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] exp, ev;
        logic [3:0] ids [6];
        m_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (busy !== 1'b0 || inv_valid !== 1'b0 || ovf !== 1'b0) begin
            errors++;
            $display("FAIL R1: busy=%b inv_valid=%b ovf=%b expected 0 0 0", busy, inv_valid, ovf);
        end
        issue(2'd2, 4'd7);
        chk_emit("R1 empty after reset", 16'h0000);

        // R10: clear empties entry
        issue(2'd0, 4'd1); issue(2'd0, 4'd2); issue(2'd0, 4'd3); issue(2'd0, 4'd4);
        chk_ovf("R6 overflow raised", 1'b1);
        issue(2'd3, 4'd0);
        chk_ovf("R10 clear lowers ovf", 1'b0);
        issue(2'd2, 4'd0);
        chk_emit("R10 clear empties", 16'h0000);
        issue(2'd3, 4'd0);

        // sweep: policies x writers x sharer counts x removal
        for (int md = 0; md < 4; md++) begin
            for (int w = 0; w < NPROC; w++) begin
                for (int n = 0; n < 6; n++) begin
                    for (int rm = 0; rm < 2; rm++) begin
                        mode = md[1:0];
                        issue(2'd3, 4'd0); m_clear();
                        chk_emit("R10 clear emits nothing", 16'h0000);
                        for (int k = 0; k < 6; k++) ids[k] = 4'((w * 5 + k * 7 + 3 + md) % NPROC);
                        for (int k = 0; k < n; k++) begin
                            issue(2'd0, ids[k]); m_add(ids[k], md, ev);
                            chk_emit(md == 1 ? "R7 eviction" : "R2 add", ev);
                            chk_ovf(md == 2 ? "R8 coarse ovf" : "R6 ovf status", m_bc | m_cv);
                        end
                        if (rm == 1 && n > 0) begin
                            issue(2'd1, ids[0]); m_remove(ids[0]);
                            issue(2'd0, ids[n-1]); m_add(ids[n-1], md, ev);
                            chk_emit("R3 remove then duplicate add", ev);
                        end else if (n > 0) begin
                            issue(2'd0, ids[0]); m_add(ids[0], md, ev);
                            chk_emit("R2 repeated add", ev);
                        end
                        issue(2'd2, 4'(w)); m_winv(4'(w), exp);
                        chk_emit(md == 2 ? "R4 R8 coarse targets" :
                                 (md == 1 ? "R4 R7 pointer targets" : "R4 R6 broadcast targets"), exp);
                        chk_ovf("R5 ovf low after write", 1'b0);
                        issue(2'd2, 4'((w + 1) % NPROC)); m_winv(4'((w + 1) % NPROC), exp);
                        chk_emit("R5 writer sole sharer", exp);
                    end
                end
            end
        end

        // R9: requests during a busy list are dropped
        mode = 2'd0;
        issue(2'd3, 4'd0);
        issue(2'd0, 4'd1); issue(2'd0, 4'd2); issue(2'd0, 4'd3); issue(2'd0, 4'd4);
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'd2; op_id = 4'd0;
        @(negedge clk);
        op_code = 2'd0; op_id = 4'd9;
        repeat (3) @(negedge clk);
        op_code = 2'd3;
        repeat (3) @(negedge clk);
        op_valid = 1'b0;
        while (busy) @(negedge clk);
        chk_ovf("R9 ovf after write", 1'b0);
        issue(2'd2, 4'd5);
        chk_emit("R9 busy requests ignored", 16'h0001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule